// File: doc/BRIEF.md
# Packed Saturating Add and Average Unit

This block is a SIMD arithmetic stage. It takes two 64-bit operands and treats each one as a row of equal lanes that are 8, 16 or 32 bits wide. It applies the same lane operation to every pair of lanes. The operations are wrapping add and subtract, clamped add and subtract, and three halving operations: a truncating mean, a mean that rounds away from zero, and a halved difference. Each lane is computed on its own, and no carry crosses a lane boundary.

Operands enter through a valid/ready handshake together with three control fields: lane size, operation and clamp mode. The result leaves through a second valid/ready handshake one clock later, with an `out_illegal` flag that marks unsupported combinations. The block holds one result register. It takes a new item whenever that register is empty or is being drained in the same cycle, so back-pressure on the output reaches the input within the same cycle. A stalled result stays constant until it is taken.

Top module: `saa_top`

## Requirements
- R1: With `in_op`=0 (add) and `in_sat`=0 (wrap), each lane of the result is the sum of its operands modulo 2^W. `in_size` 0, 1 and 2 select W = 8, 16 and 32, and lane i occupies bits [i*W+W-1 : i*W].
- R2: With `in_op`=1 (subtract) and `in_sat`=0, each lane is a minus b, modulo 2^W, for all three lane sizes.
- R3: With `in_sat`=1, add or subtract reads both lanes as two's complement and clamps the exact result to [-2^(W-1), 2^(W-1)-1]. This mode is valid for W = 8 and W = 16 only.
- R4: With `in_sat`=2, add or subtract reads both lanes as unsigned and clamps to [0, 2^W-1]. Valid for W = 8 and W = 16.
- R5: With `in_sat`=3, add or subtract reads a as unsigned and b as two's complement, and clamps to [0, 2^W-1]. Valid for W = 8 and W = 16.
- R6: With `in_op`=2 (mean), each lane is the (W+1)-bit unsigned sum of the lanes shifted right by one, so the carry out of the sum becomes the top result bit.
- R7: With `in_op`=3 (rounded mean), each lane is (a + b + 1) computed in W+1 bits and shifted right by one.
- R8: With `in_op`=4 (halved difference), each lane is bits [W:1] of the (W+1)-bit difference of the zero-extended lanes.
- R9: The following inputs set `out_illegal` to 1 and force `out_data` to zero: `in_size`=3, `in_op` of 5 to 7, a nonzero `in_sat` with `in_size`=2, and ops 2 to 4 with `in_size`=2 or with a nonzero `in_sat`. Every other combination sets `out_illegal` to 0.
- R10: An input is taken on a rising edge where `in_valid` and `in_ready` are both high, and its result is presented on `out_valid` at the next edge. `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_illegal` hold.
- R11: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand item present |
| in_ready | output | 1 | Block can take an item this cycle |
| in_a | input | 64 | First operand, packed lanes |
| in_b | input | 64 | Second operand, packed lanes |
| in_size | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32 bits |
| in_op | input | 3 | 0 add, 1 sub, 2 mean, 3 rounded mean, 4 halved difference |
| in_sat | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp (b unsigned), 3 unsigned clamp (b signed) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Packed result |
| out_illegal | output | 1 | Unsupported combination; data is zero |

## Verification
Every result is due exactly one clock after the edge that accepts its operands. From then on it waits in the output register for as many cycles as `out_ready` stays low. The driver samples `in_ready` at the falling edge before the accepting edge, and it queues the reference result at that moment. The monitor compares results at falling edges, and only for cycles in which `out_valid` and `out_ready` are both high, so queue order stands in for the one-cycle latency. During each stall cycle the monitor also checks that the held result has not changed.

// File: rtl/saa_pkg.sv
`timescale 1ns/1ps
package saa_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MEAN = 3'd2,
    OP_MEANR = 3'd3,
    OP_HDIFF = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    CL_WRAP = 2'd0,
    CL_SS   = 2'd1,
    CL_UU   = 2'd2,
    CL_US   = 2'd3
  } clamp_e;

  typedef enum logic [1:0] {
    LS_8  = 2'd0,
    LS_16 = 2'd1,
    LS_32 = 2'd2,
    LS_RSV = 2'd3
  } lsize_e;

  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned BASE_LANE_W = 8;
endpackage

// File: rtl/saa_lane.sv
`timescale 1ns/1ps
module saa_lane
  import saa_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_e          op,
  input  clamp_e       clamp,
  output logic [W-1:0] y
);
  localparam int unsigned WE = W + 2;
  localparam logic signed [WE-1:0] SMAX = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [WE-1:0] SMIN = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [WE-1:0] UMAX = {2'b00, {W{1'b1}}};

  logic              a_sx, b_sx, do_sub, rnd;
  logic [WE-1:0]     ax, bx;
  logic signed [WE-1:0] r;

  always_comb begin
    a_sx   = (clamp == CL_SS);
    b_sx   = (clamp == CL_SS) || (clamp == CL_US);
    ax     = {{2{a_sx & a[W-1]}}, a};
    bx     = {{2{b_sx & b[W-1]}}, b};
    do_sub = (op == OP_SUB) || (op == OP_HDIFF);
    rnd    = (op == OP_MEANR);
    r      = do_sub ? $signed(ax - bx) : $signed(ax + bx + {{(WE-1){1'b0}}, rnd});
    y      = r[W-1:0];
    if (op == OP_MEAN || op == OP_MEANR || op == OP_HDIFF) begin
      y = r[W:1];
    end else begin
      unique case (clamp)
        CL_SS: begin
          if (r > SMAX)      y = SMAX[W-1:0];
          else if (r < SMIN) y = SMIN[W-1:0];
        end
        CL_UU, CL_US: begin
          if (r < 0)         y = '0;
          else if (r > UMAX) y = UMAX[W-1:0];
        end
        default: y = r[W-1:0];
      endcase
    end
  end

  // Unsigned clamped add never falls below its first operand.
  always_comb begin
    if (op == OP_ADD && clamp == CL_UU)
      p_usat_floor_r4: assert (y >= a);
  end

  // Signed clamped add of two non-negative lanes stays non-negative.
  always_comb begin
    if (op == OP_ADD && clamp == CL_SS && !a[W-1] && !b[W-1])
      p_ssat_sign_r3: assert (!y[W-1]);
  end
endmodule

// File: rtl/saa_bank.sv
`timescale 1ns/1ps
module saa_bank
  import saa_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned W  = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  op_e           op,
  input  clamp_e        clamp,
  output logic [DW-1:0] y
);
  localparam int unsigned LANES = DW / W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    saa_lane #(.W(W)) u_lane (
      .a    (a[i*W +: W]),
      .b    (b[i*W +: W]),
      .op   (op),
      .clamp(clamp),
      .y    (y[i*W +: W])
    );
  end
endmodule

// File: rtl/saa_decode.sv
`timescale 1ns/1ps
module saa_decode
  import saa_pkg::*;
(
  input  lsize_e size,
  input  op_e    op,
  input  clamp_e clamp,
  output logic   legal
);
  logic known_op, is_mean, wide;

  always_comb begin
    known_op = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MEAN) ||
               (op == OP_MEANR) || (op == OP_HDIFF);
    is_mean  = (op == OP_MEAN) || (op == OP_MEANR) || (op == OP_HDIFF);
    wide     = (size == LS_32);
    legal    = known_op && (size != LS_RSV) &&
               !(wide && clamp != CL_WRAP) &&
               !(is_mean && (wide || clamp != CL_WRAP));
  end
endmodule

// File: rtl/saa_top.sv
`timescale 1ns/1ps
module saa_top
  import saa_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_size,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_sat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  op_e    op;
  clamp_e clamp;
  lsize_e size;
  logic   legal;
  logic   take;
  logic [NUM_SIZES-1:0][DATA_W-1:0] bank_y;
  logic [DATA_W-1:0] sel_y;

  assign op    = op_e'(in_op);
  assign clamp = clamp_e'(in_sat);
  assign size  = lsize_e'(in_size);

  saa_decode u_dec (
    .size (size),
    .op   (op),
    .clamp(clamp),
    .legal(legal)
  );

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    saa_bank #(.DW(DATA_W), .W(BASE_LANE_W << s)) u_bank (
      .a    (in_a),
      .b    (in_b),
      .op   (op),
      .clamp(clamp),
      .y    (bank_y[s])
    );
  end

  always_comb begin
    sel_y = '0;
    if (legal) begin
      unique case (size)
        LS_8:    sel_y = bank_y[0];
        LS_16:   sel_y = bank_y[1];
        LS_32:   sel_y = bank_y[2];
        default: sel_y = '0;
      endcase
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_data    <= sel_y;
        out_illegal <= !legal;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_data == '0));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));

  p_accept_due_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_reset_idle_r11: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/tb_saa_top.sv
`timescale 1ns/1ps
module tb_saa_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_size = '0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_sat = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  bit stall_on = 1'b0;
  bit done = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  saa_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_size(in_size), .in_op(in_op), .in_sat(in_sat),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_illegal(out_illegal)
  );

  function automatic string req_of(int sz, int op, int sat, bit ill);
    if (ill) return "R9";
    if (op == 2) return "R6";
    if (op == 3) return "R7";
    if (op == 4) return "R8";
    if (sat == 1) return "R3";
    if (sat == 2) return "R4";
    if (sat == 3) return "R5";
    if (op == 1) return "R2";
    return "R1";
  endfunction

  function automatic bit ref_illegal(int sz, int op, int sat);
    if (sz == 3 || op > 4) return 1'b1;
    if (sz == 2 && sat != 0) return 1'b1;
    if (op >= 2 && (sz == 2 || sat != 0)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] ref_data(logic [63:0] a, logic [63:0] b,
                                           int sz, int op, int sat);
    logic [63:0] res = '0;
    int    w = 8 << sz;
    longint full = longint'(1) << w;
    longint half = full >> 1;
    longint mask = full - 1;
    for (int i = 0; i < 64 / w; i++) begin
      longint ua = longint'((a >> (i * w))) & mask;
      longint ub = longint'((b >> (i * w))) & mask;
      longint sa = (ua >= half) ? ua - full : ua;
      longint sb = (ub >= half) ? ub - full : ub;
      longint r;
      longint lo, hi, x, y;
      if (op == 2)      r = (ua + ub) >> 1;
      else if (op == 3) r = (ua + ub + 1) >> 1;
      else if (op == 4) r = ((ua - ub) & (2 * full - 1)) >> 1;
      else begin
        x = (sat == 1) ? sa : ua;
        y = (sat == 1 || sat == 3) ? sb : ub;
        r = (op == 1) ? x - y : x + y;
        if (sat == 1) begin lo = -half; hi = half - 1; end
        else begin lo = 0; hi = full - 1; end
        if (sat != 0) begin
          if (r < lo) r = lo;
          if (r > hi) r = hi;
        end
      end
      res = res | (64'(r & mask) << (i * w));
    end
    return res;
  endfunction

  task automatic send(logic [63:0] a, logic [63:0] b, int sz, int op, int sat);
    bit ill = ref_illegal(sz, op, sat);
    bit acc = 1'b0;
    @(negedge clk);
    in_a = a; in_b = b; in_size = 2'(sz); in_op = 3'(op); in_sat = 2'(sat);
    in_valid = 1'b1;
    while (!acc) begin
      if (in_ready) begin
        acc = 1'b1;
        exp_q.push_back({ill, ill ? 64'd0 : ref_data(a, b, sz, op, sat)});
        tag_q.push_back(req_of(sz, op, sat, ill));
        pushed++;
      end
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  // Back-pressure pattern, changed just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = stall_on ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Monitor: compare results as the design hands them over.
  initial begin
    logic [64:0] held;
    bit          was_stalled = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_stalled) begin
          checks++;
          if (!out_valid || {out_illegal, out_data} != held) begin
            errors++;
            $display("FAIL R10 stall hold: got v=%0b %h/%0b exp %h/%0b",
                     out_valid, out_data, out_illegal, held[63:0], held[64]);
          end
        end
        if (out_valid && out_ready) begin
          logic [64:0] e;
          string t;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected result %h, expected none", out_data);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            popped++;
            if ({out_illegal, out_data} != e) begin
              errors++;
              $display("FAIL %s data=%h ill=%0b expected data=%h ill=%0b",
                       t, out_data, out_illegal, e[63:0], e[64]);
            end
          end
        end
        was_stalled = out_valid && !out_ready;
        held = {out_illegal, out_data};
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [63:0] pats [8];

  initial begin
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h7F7F_7FFF_7FFF_FFFF;
    pats[3] = 64'h8080_8000_8000_0000;
    pats[4] = 64'h7FFF_FFFF_8000_0001;
    pats[5] = 64'h0123_4567_89AB_CDEF;
    pats[6] = 64'h0101_0001_0000_0001;
    pats[7] = 64'hFF00_80FF_7F01_FE80;

    // R11: output idle during reset.
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 out_valid=%0b expected 0", out_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: every control combination over boundary patterns.
    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 8; op++)
        for (int sat = 0; sat < 4; sat++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j += 3)
              send(pats[i], pats[j], sz, op, sat);

    // Random operands with back-pressure.
    stall_on = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      send(ra, rb, $urandom % 4, $urandom % 6, $urandom % 4);
    end
    stall_on = 1'b0;

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (pushed != popped) begin
      errors++;
      $display("FAIL R10 results delivered %0d expected %0d", popped, pushed);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule